// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block takes one DMA transfer request, already granted by the channel logic, and carries it out as a pair of bus transactions on a simple master interface. The I/O transaction and the memory transaction are issued one after the other, in the order the direction requires. Each request carries a channel number, a direction, a cycle kind (normal or verify), a terminal-count flag and a memory address.

The block builds the I/O-side address from the cycle kind and the terminal-count flag. The I/O byte enables and data lanes follow the channel width. Channels below the cascade channel are 8 bits wide and channels above it are 16 bits wide. On the memory side, the byte enables and the data lane follow the low address bits.

Each transfer moves exactly one unit between one I/O access and one memory access, with no packing into wider words. Verify cycles only read from the device. A request on the cascade channel is refused with an error pulse, and no bus cycle is issued for it.

Top module: `dma_pair_seq`

## Requirements
- R1: The I/O phase address is 0x00 for a normal cycle, 0x04 for normal at terminal count, 0xC0 for verify and 0xC4 for verify at terminal count.
- R2: A verify request issues exactly one bus transaction, an I/O read (command 4'b0010), whatever the direction input says. No memory transaction follows.
- R3: An I/O transaction starts (bus_valid rises) only if gnt was high in the cycle before. While gnt stays low, the block waits with bus_valid low.
- R4: A normal device-to-memory request (req_to_dev=0) issues an I/O read (4'b0010) and then one memory write (4'b0111) to req_maddr. The memory write carries the unit that was read.
- R5: A normal memory-to-device request (req_to_dev=1) issues a memory read (4'b0110) from req_maddr and then one I/O write (4'b0011). The I/O write carries the unit taken from the read data.
- R6: On I/O transactions the active-low byte enables are 4'b1110 for channels 0-3 and 4'b1100 for channels 5-7. The data sits on bits [7:0] or [15:0], and all higher bits of I/O write data are zero. Only those low bits of I/O read data are kept.
- R7: On memory transactions an 8-bit channel enables byte lane maddr[1:0] (be_n = ~(1<<lane)). A 16-bit channel enables halfword maddr[1] (be_n = ~(3<<2*maddr[1])). Write data is shifted into that lane, and read data is taken from it.
- R8: A request on channel 4 raises err for one cycle in the cycle after it is taken. No bus transaction is issued and idle stays high.
- R9: done is high for exactly one cycle, in the cycle after the last transaction's ack is sampled.
- R10: A request presented while idle is low is ignored.
- R11: Once bus_valid is high, address, command, byte enables and write data hold steady until bus_ack is sampled.
- R12: After reset, idle is 1 and bus_valid, done and err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_chan | input | CH_W | Channel number |
| req_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| req_verify | input | 1 | Verify cycle kind |
| req_tc | input | 1 | Terminal count reached |
| req_maddr | input | AW | Memory address |
| idle | output | 1 | Ready for a new request |
| gnt | input | 1 | Grant for the requesting device |
| bus_valid | output | 1 | Transaction in progress |
| bus_addr | output | AW | Transaction address |
| bus_cmd | output | 4 | Transaction command |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transaction complete |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Cascade channel rejection pulse |

## Verification
The hardest situation to reach from the ports is a request arriving while a transfer is stalled. Here the block has taken a request, gnt is held low, and a second request appears on the input. The bench holds gnt low for several cycles after a request is taken and presents a cascade-channel request during that window. It then checks that no err pulse appears and that the transfer count stays correct. Random transfers with random ack latency and random grant gaps then cover every width, lane, direction and cycle-kind combination.

// File: rtl/dma_pair_pkg.sv
package dma_pair_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_st_t;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef struct packed {
    logic wide;
    logic to_dev;
    logic verify;
    logic tc;
  } xfer_ctl_t;

endpackage

// File: rtl/dma_io_encode.sv
module dma_io_encode #(
  parameter int AW = 32
) (
  input  logic          verify,
  input  logic          tc,
  input  logic          wide,
  output logic [AW-1:0] io_addr,
  output logic [3:0]    io_be_n
);
  localparam logic [7:0] VERIFY_OFS = 8'hC0;
  localparam logic [7:0] TC_OFS     = 8'h04;

  logic [7:0] lo8;

  always_comb begin
    lo8 = 8'h00;
    if (verify) lo8 = lo8 | VERIFY_OFS;
    if (tc)     lo8 = lo8 | TC_OFS;
  end

  assign io_addr = {{(AW-8){1'b0}}, lo8};
  assign io_be_n = wide ? 4'b1100 : 4'b1110;
endmodule

// File: rtl/dma_lane_align.sv
module dma_lane_align #(
  parameter int DW = 32
) (
  input  logic          wide,
  input  logic [1:0]    lane_lo,
  input  logic [15:0]   unit_in,
  input  logic [DW-1:0] rdata,
  output logic [3:0]    be_n,
  output logic [DW-1:0] placed,
  output logic [15:0]   picked
);
  logic [4:0]    shamt;
  logic [15:0]   umask;
  logic [DW-1:0] shifted_rd;

  always_comb begin
    if (wide) begin
      shamt = {lane_lo[1], 4'b0000};
      umask = 16'hFFFF;
      be_n  = ~(4'b0011 << {lane_lo[1], 1'b0});
    end else begin
      shamt = {lane_lo, 3'b000};
      umask = 16'h00FF;
      be_n  = ~(4'b0001 << lane_lo);
    end
    placed     = {{(DW-16){1'b0}}, unit_in & umask} << shamt;
    shifted_rd = rdata >> shamt;
    picked     = shifted_rd[15:0] & umask;
  end
endmodule

// File: rtl/dma_pair_seq.sv
module dma_pair_seq #(
  parameter int AW         = 32,
  parameter int CH_W       = 3,
  parameter int CASCADE_CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [CH_W-1:0] req_chan,
  input  logic            req_to_dev,
  input  logic            req_verify,
  input  logic            req_tc,
  input  logic [AW-1:0]   req_maddr,
  output logic            idle,
  input  logic            gnt,
  output logic            bus_valid,
  output logic [AW-1:0]   bus_addr,
  output logic [3:0]      bus_cmd,
  output logic [3:0]      bus_be_n,
  output logic [31:0]     bus_wdata,
  input  logic [31:0]     bus_rdata,
  input  logic            bus_ack,
  output logic            done,
  output logic            err
);
  import dma_pair_pkg::*;

  localparam int DW = 32;
  localparam logic [CH_W-1:0] CASC = CH_W'(CASCADE_CH);

  seq_st_t    st;
  xfer_ctl_t  ctl;
  logic [AW-1:0] maddr_q;
  logic [15:0]   hold_q;

  logic          first_is_io, cur_io, last_phase, may_launch;
  logic [3:0]    io_cmd, mem_cmd, io_be_n, mem_be_n;
  logic [AW-1:0] io_addr;
  logic [15:0]   umask;
  logic [DW-1:0] mem_wdata;
  logic [15:0]   mem_picked;

  dma_io_encode #(.AW(AW)) u_io_enc (
    .verify  (ctl.verify),
    .tc      (ctl.tc),
    .wide    (ctl.wide),
    .io_addr (io_addr),
    .io_be_n (io_be_n)
  );

  dma_lane_align #(.DW(DW)) u_lane (
    .wide    (ctl.wide),
    .lane_lo (maddr_q[1:0]),
    .unit_in (hold_q),
    .rdata   (bus_rdata),
    .be_n    (mem_be_n),
    .placed  (mem_wdata),
    .picked  (mem_picked)
  );

  always_comb begin
    first_is_io = ctl.verify || !ctl.to_dev;
    cur_io      = (st == ST_FIRST) ? first_is_io : !first_is_io;
    last_phase  = (st == ST_SECOND) || ctl.verify;
    io_cmd      = (ctl.to_dev && !ctl.verify) ? CMD_IO_WR : CMD_IO_RD;
    mem_cmd     = ctl.to_dev ? CMD_MEM_RD : CMD_MEM_WR;
    umask       = ctl.wide ? 16'hFFFF : 16'h00FF;
    may_launch  = (st != ST_IDLE) && !bus_valid && (!cur_io || gnt);
  end

  assign idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ctl       <= '0;
      maddr_q   <= '0;
      hold_q    <= '0;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_cmd   <= '0;
      bus_be_n  <= 4'hF;
      bus_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_chan == CASC) begin
              err <= 1'b1;
            end else begin
              ctl.wide   <= (req_chan > CASC);
              ctl.to_dev <= req_to_dev;
              ctl.verify <= req_verify;
              ctl.tc     <= req_tc;
              maddr_q    <= req_maddr;
              st         <= ST_FIRST;
            end
          end
        end
        default: begin
          if (may_launch) begin
            bus_valid <= 1'b1;
            if (cur_io) begin
              bus_addr  <= io_addr;
              bus_cmd   <= io_cmd;
              bus_be_n  <= io_be_n;
              bus_wdata <= (io_cmd == CMD_IO_WR) ? {16'h0000, hold_q & umask} : '0;
            end else begin
              bus_addr  <= maddr_q;
              bus_cmd   <= mem_cmd;
              bus_be_n  <= mem_be_n;
              bus_wdata <= (mem_cmd == CMD_MEM_WR) ? mem_wdata : '0;
            end
          end else if (bus_valid && bus_ack) begin
            bus_valid <= 1'b0;
            if (bus_cmd == CMD_IO_RD)  hold_q <= bus_rdata[15:0] & umask;
            if (bus_cmd == CMD_MEM_RD) hold_q <= mem_picked;
            if (last_phase) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_SECOND;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_pair_seq_chk.sv
module dma_pair_seq_chk #(
  parameter int AW         = 32,
  parameter int CH_W       = 3,
  parameter int CASCADE_CH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [CH_W-1:0] req_chan,
  input logic            idle,
  input logic            gnt,
  input logic            bus_valid,
  input logic [AW-1:0]   bus_addr,
  input logic [3:0]      bus_cmd,
  input logic            bus_ack,
  input logic            done,
  input logic            err
);
  localparam logic [3:0] IO_RD = 4'b0010;
  localparam logic [3:0] IO_WR = 4'b0011;

  AST_IO_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_valid) && (bus_cmd == IO_RD || bus_cmd == IO_WR)) |-> $past(gnt)); // R3

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_cmd))); // R11

  AST_CASCADE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && idle && req_chan == CH_W'(CASCADE_CH)) |=> (err && !bus_valid && idle)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_IO_WRITE_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_cmd == IO_WR) |-> (bus_addr == AW'(0) || bus_addr == AW'(4))); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    idle |-> !bus_valid); // R10
endmodule

bind dma_pair_seq dma_pair_seq_chk #(.AW(AW), .CH_W(CH_W), .CASCADE_CH(CASCADE_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_chan  (req_chan),
  .idle      (idle),
  .gnt       (gnt),
  .bus_valid (bus_valid),
  .bus_addr  (bus_addr),
  .bus_cmd   (bus_cmd),
  .bus_ack   (bus_ack),
  .done      (done),
  .err       (err)
);

// File: tb/test_dma_pair_seq.sv
module test_dma_pair_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] IOR = 4'b0010, IOW = 4'b0011, MRD = 4'b0110, MWR = 4'b0111;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_to_dev = 0, req_verify = 0, req_tc = 0;
  logic [2:0] req_chan = 0;
  logic [31:0] req_maddr = 0;
  logic idle, gnt = 1, bus_valid, bus_ack, done, err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0] bus_cmd, bus_be_n;

  int n_chk = 0, n_err = 0, cyc = 0, ack_cyc = 0, lg_n = 0;
  logic [31:0] lg_addr [0:3];
  logic [31:0] lg_wd [0:3];
  logic [31:0] lg_rd [0:3];
  logic [3:0]  lg_cmd [0:3];
  logic [3:0]  lg_be [0:3];

  dma_pair_seq i_dma_pair_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_to_dev(req_to_dev), .req_verify(req_verify), .req_tc(req_tc),
    .req_maddr(req_maddr), .idle(idle), .gnt(gnt), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_be_n(bus_be_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bus responder with random ack latency
  initial begin
    int dly;
    dly = 0;
    bus_ack = 0;
    bus_rdata = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 0;
      else if (bus_valid) begin
        if (dly == 0) begin
          bus_rdata = $urandom;
          if (lg_n < 4) begin
            lg_addr[lg_n] = bus_addr; lg_cmd[lg_n] = bus_cmd;
            lg_be[lg_n] = bus_be_n; lg_wd[lg_n] = bus_wdata; lg_rd[lg_n] = bus_rdata;
          end
          lg_n++;
          bus_ack = 1;
          ack_cyc = cyc;
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_io_addr(input bit ver, input bit tc);
    return ver ? (tc ? 32'hC4 : 32'hC0) : (tc ? 32'h04 : 32'h00);
  endfunction

  function automatic logic [3:0] exp_mem_be(input bit wide, input logic [1:0] a);
    return wide ? (a[1] ? 4'b0011 : 4'b1100) : ~(4'b0001 << a);
  endfunction

  function automatic int lane_sh(input bit wide, input logic [1:0] a);
    return wide ? 16 * a[1] : 8 * a;
  endfunction

  task automatic start_req(input logic [2:0] ch, input bit to_dev, input bit ver,
                           input bit tc, input logic [31:0] ma);
    @(negedge clk);
    lg_n = 0;
    req_chan = ch; req_to_dev = to_dev; req_verify = ver; req_tc = tc; req_maddr = ma;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    bit seen;
    seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (done) begin
        seen = 1;
        check(cyc == ack_cyc + 1, "R9 done timing", cyc, ack_cyc + 1);
      end else @(negedge clk);
    end
    check(seen, "R9 done seen", 32'(seen), 1);
    @(negedge clk);
    check(done == 0, "R9 done one cycle", 32'(done), 0);
  endtask

  task automatic check_xfer(input logic [2:0] ch, input bit to_dev, input bit ver,
                            input bit tc, input logic [31:0] ma);
    bit wide;
    logic [31:0] m;
    int sh;
    wide = ch > 4;
    m = wide ? 32'hFFFF : 32'hFF;
    sh = lane_sh(wide, ma[1:0]);
    if (ver) begin
      check(lg_n == 1, "R2 verify count", 32'(lg_n), 1);
      check(lg_cmd[0] == IOR, "R2 verify cmd", 32'(lg_cmd[0]), 32'(IOR));
      check(lg_addr[0] == exp_io_addr(1, tc), "R1 verify addr", lg_addr[0], exp_io_addr(1, tc));
    end else if (!to_dev) begin
      check(lg_n == 2, "R4 count", 32'(lg_n), 2);
      check(lg_cmd[0] == IOR && lg_cmd[1] == MWR, "R4 order",
            {24'h0, lg_cmd[0], lg_cmd[1]}, {24'h0, IOR, MWR});
      check(lg_addr[0] == exp_io_addr(0, tc), "R1 io addr", lg_addr[0], exp_io_addr(0, tc));
      check(lg_be[0] == (wide ? 4'b1100 : 4'b1110), "R6 io be", 32'(lg_be[0]),
            wide ? 32'hC : 32'hE);
      check(lg_addr[1] == ma, "R4 mem addr", lg_addr[1], ma);
      check(lg_be[1] == exp_mem_be(wide, ma[1:0]), "R7 mem be", 32'(lg_be[1]),
            32'(exp_mem_be(wide, ma[1:0])));
      check(lg_wd[1] == ((lg_rd[0] & m) << sh), "R7 mem wdata lane", lg_wd[1],
            (lg_rd[0] & m) << sh);
    end else begin
      check(lg_n == 2, "R5 count", 32'(lg_n), 2);
      check(lg_cmd[0] == MRD && lg_cmd[1] == IOW, "R5 order",
            {24'h0, lg_cmd[0], lg_cmd[1]}, {24'h0, MRD, IOW});
      check(lg_addr[0] == ma, "R5 mem addr", lg_addr[0], ma);
      check(lg_be[0] == exp_mem_be(wide, ma[1:0]), "R7 mem rd be", 32'(lg_be[0]),
            32'(exp_mem_be(wide, ma[1:0])));
      check(lg_addr[1] == exp_io_addr(0, tc), "R1 io addr", lg_addr[1], exp_io_addr(0, tc));
      check(lg_be[1] == (wide ? 4'b1100 : 4'b1110), "R6 io be", 32'(lg_be[1]),
            wide ? 32'hC : 32'hE);
      check(lg_wd[1] == ((lg_rd[0] >> sh) & m), "R6 io wdata", lg_wd[1], (lg_rd[0] >> sh) & m);
    end
  endtask

  task automatic do_xfer(input logic [2:0] ch, input bit to_dev, input bit ver,
                         input bit tc, input logic [31:0] ma);
    start_req(ch, to_dev, ver, tc, ma);
    wait_done();
    check_xfer(ch, to_dev, ver, tc, ma);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(idle && !bus_valid && !done && !err, "R12 reset state",
          {28'h0, idle, bus_valid, done, err}, 32'h8);

    // directed: every cycle kind, both widths, corner lanes
    do_xfer(3'd0, 0, 0, 0, 32'h1000_0003);
    do_xfer(3'd3, 1, 0, 1, 32'h2000_0001);
    do_xfer(3'd5, 0, 0, 1, 32'h3000_0002);
    do_xfer(3'd7, 1, 0, 0, 32'h4000_0000);
    do_xfer(3'd1, 0, 1, 0, 32'h0);
    do_xfer(3'd6, 1, 1, 1, 32'h0);

    // R8 cascade channel rejected
    start_req(3'd4, 0, 0, 0, 32'h55);
    check(err == 1, "R8 err pulse", 32'(err), 1);
    check(idle && !bus_valid, "R8 no bus", {30'h0, idle, bus_valid}, 32'h2);
    @(negedge clk);
    check(err == 0 && lg_n == 0, "R8 err single, no transaction", {31'h0, err} | lg_n, 0);

    // R3 grant held low, R10 request while busy ignored
    gnt = 0;
    start_req(3'd2, 0, 0, 0, 32'h0000_0011);
    req_chan = 3'd4; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(err == 0, "R10 busy request ignored", 32'(err), 0);
    for (int i = 0; i < 5; i++) begin
      check(!bus_valid, "R3 wait for grant", 32'(bus_valid), 0);
      @(negedge clk);
    end
    gnt = 1;
    wait_done();
    check_xfer(3'd2, 0, 0, 0, 32'h0000_0011);

    // random transfers with random grant gaps
    for (int k = 0; k < 60; k++) begin
      logic [2:0] ch;
      bit td, vf, tc;
      logic [31:0] ma;
      ch = 3'($urandom % 7);
      if (ch >= 3'd4) ch = ch + 3'd1;
      td = 1'($urandom); vf = ($urandom % 4) == 0; tc = 1'($urandom);
      ma = $urandom;
      gnt = ($urandom % 3) != 0;
      start_req(ch, td, vf, tc, ma);
      repeat ($urandom % 3) @(negedge clk);
      gnt = 1;
      wait_done();
      check_xfer(ch, td, vf, tc, ma);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule